// File: doc/BRIEF.md
# Privileged Return and System-Instruction Unit

This unit executes the privileged system group of a small RISC-style core: environment call, breakpoint, and the three trap returns (user, supervisor, machine). Each instruction arrives with a one-cycle valid strobe, the 32-bit instruction word and the program counter. One clock edge later the unit gives a response: a next-PC value, and, when the instruction must trap, a fault flag with a cause code and a fault value.

The unit holds the current privilege level and the interrupt-enable stack (current enable, previous enable and previous privilege for each mode). A legal return pops that stack. It copies the previous enable into the current enable, sets the previous enable, moves the previous privilege into the current privilege, sets the previous-privilege field to user, and redirects to the matching exception PC. The exception PCs come in on input ports. A return issued at too low a privilege traps as an illegal instruction, and the state stays as it was. Trap entry is not part of this unit. It writes the state through a load port, which takes priority over an instruction in the same cycle.

Top module: `sysret_unit`

## Requirements
- R1: After reset, `state_q` equals 11'b000_000_0_00_11 (machine privilege, every enable, previous-enable and previous-privilege bit zero), and `resp_valid` and `fault_valid` are 0.
- R2: An instruction is legal only if bits [6:0] are 7'b1110011, bits [14:12] are zero, bits [11:7] are zero, bits [19:15] are zero, and bits [31:20] hold 0x000, 0x001, 0x002, 0x102 or 0x302. Any other word faults with cause 2, fault value equal to the zero-extended word, next PC equal to PC+4, and unchanged state.
- R3: Function 0x000 (environment call) faults with cause 8 plus the current privilege (8 user, 9 supervisor, 11 machine), fault value 0 and next PC equal to PC+4. The state does not change.
- R4: Function 0x001 (breakpoint) faults with cause 3, fault value equal to the PC and next PC equal to PC+4. The state does not change.
- R5: Function 0x002 (user return) is legal at every privilege. It sets the user enable from the user previous-enable, sets the user previous-enable to 1, leaves the privilege as it is, and sets next PC to `uepc`.
- R6: Function 0x102 (supervisor return) at supervisor or machine privilege sets the privilege to the supervisor previous-privilege bit (0 user, 1 supervisor), copies the supervisor previous-enable into the supervisor enable, sets the supervisor previous-enable to 1, clears the previous-privilege bit, and sets next PC to `sepc`.
- R7: A supervisor return at user privilege faults with cause 2, next PC equal to PC+4, and unchanged state.
- R8: Function 0x302 (machine return) at machine privilege sets the privilege to the machine previous-privilege field, copies the machine previous-enable into the machine enable, sets the machine previous-enable to 1, sets the previous-privilege field to user (2'b00), and sets next PC to `mepc`.
- R9: A machine return at user or supervisor privilege faults with cause 2, next PC equal to PC+4, and unchanged state.
- R10: The response registers update on the edge that samples the strobe. `resp_valid` is high for exactly one cycle per accepted strobe, `fault_valid` is never high without `resp_valid`, and without a strobe or load the state holds.
- R11: The state layout is bit 10 user enable, 9 supervisor enable, 8 machine enable, 7 user previous-enable, 6 supervisor previous-enable, 5 machine previous-enable, 4 supervisor previous-privilege, [3:2] machine previous-privilege, [1:0] privilege (00 user, 01 supervisor, 11 machine). `state_ld` writes `state_ld_val` on the next edge, and a reserved code 2'b10 in either privilege field is stored as 2'b11.
- R12: When `state_ld` and `instr_valid` are high in the same cycle, the load is applied and the instruction is dropped: it gives no response and does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction strobe |
| instr_word | input | 32 | Instruction word |
| cur_pc | input | XLEN | PC of the instruction |
| uepc | input | XLEN | User exception PC |
| sepc | input | XLEN | Supervisor exception PC |
| mepc | input | XLEN | Machine exception PC |
| state_ld | input | 1 | Load strobe from trap-entry logic |
| state_ld_val | input | 11 | State value to load |
| resp_valid | output | 1 | Response pulse |
| next_pc | output | XLEN | PC to continue from |
| fault_valid | output | 1 | Instruction traps |
| fault_cause | output | CAUSE_W | Trap cause code |
| fault_value | output | XLEN | Trap value (PC or word) |
| state_q | output | 11 | Privilege and enable-stack state |

## Verification
The bench targets the privilege gate on returns. A supervisor return at user privilege and a machine return at supervisor or user privilege must trap and leave the state untouched; a design with a loose check would pop the stack and jump to the exception PC instead. It also checks every previous-privilege value a machine return can restore, including a return to machine itself. A design that forgot to clear the field to user, or that swapped the enable and previous-enable moves, would leave the wrong bits in `state_q`. The remaining cases cover near-miss encodings (nonzero register fields, nonzero funct3, wrong opcode), the privilege tag in the environment-call cause, reserved-privilege coercion on load, and a load that collides with an instruction. A design that got these wrong would either accept a bad word or let the dropped instruction leak a response.

// File: rtl/sysret_pkg.sv
`timescale 1ns/1ps
package sysret_pkg;

   localparam int STATE_W = 11;

   localparam logic [1:0] PRIV_USER = 2'b00;
   localparam logic [1:0] PRIV_SUPV = 2'b01;
   localparam logic [1:0] PRIV_RSVD = 2'b10;
   localparam logic [1:0] PRIV_MACH = 2'b11;

   localparam logic [6:0]  OPC_SYS   = 7'b1110011;
   localparam logic [11:0] FN_ECALL  = 12'h000;
   localparam logic [11:0] FN_EBREAK = 12'h001;
   localparam logic [11:0] FN_URET   = 12'h002;
   localparam logic [11:0] FN_SRET   = 12'h102;
   localparam logic [11:0] FN_MRET   = 12'h302;

   localparam int CAUSE_ILLEGAL    = 2;
   localparam int CAUSE_BREAK      = 3;
   localparam int CAUSE_ECALL_BASE = 8;

   typedef struct packed {
      logic       uie;
      logic       sie;
      logic       mie;
      logic       upie;
      logic       spie;
      logic       mpie;
      logic       spp;
      logic [1:0] mpp;
      logic [1:0] priv;
   } hart_state_t;

   typedef enum logic [2:0] {
      OP_ECALL,
      OP_EBREAK,
      OP_URET,
      OP_SRET,
      OP_MRET,
      OP_ILLEGAL
   } sys_op_e;

   function automatic logic [1:0] fix_priv(input logic [1:0] p);
      return (p == PRIV_RSVD) ? PRIV_MACH : p;
   endfunction

endpackage

// File: rtl/sysret_decode.sv
`timescale 1ns/1ps
module sysret_decode
   import sysret_pkg::*;
#(
   parameter bit HAS_URET  = 1'b1,
   parameter bit HAS_SMODE = 1'b1
)(
   input  logic [31:0] instr,
   input  logic [1:0]  priv,
   output sys_op_e     op
);

   logic [6:0]  f_opc;
   logic [4:0]  f_rd;
   logic [2:0]  f_fn3;
   logic [4:0]  f_rs1;
   logic [11:0] f_fn12;
   logic        shape_ok;
   logic        hit_ecall;
   logic        hit_ebreak;
   logic        hit_uret;
   logic        hit_sret;
   logic        hit_mret;
   logic        sret_allowed;
   logic        mret_allowed;

   assign f_opc  = instr[6:0];
   assign f_rd   = instr[11:7];
   assign f_fn3  = instr[14:12];
   assign f_rs1  = instr[19:15];
   assign f_fn12 = instr[31:20];

   assign shape_ok = (f_opc == OPC_SYS) && (f_fn3 == 3'd0) &&
                     (f_rd == 5'd0) && (f_rs1 == 5'd0);

   assign hit_ecall  = shape_ok && (f_fn12 == FN_ECALL);
   assign hit_ebreak = shape_ok && (f_fn12 == FN_EBREAK);
   assign hit_mret   = shape_ok && (f_fn12 == FN_MRET);

   generate
      if (HAS_URET) begin : g_uret
         assign hit_uret = shape_ok && (f_fn12 == FN_URET);
      end else begin : g_no_uret
         assign hit_uret = 1'b0;
      end
      if (HAS_SMODE) begin : g_sret
         assign hit_sret = shape_ok && (f_fn12 == FN_SRET);
      end else begin : g_no_sret
         assign hit_sret = 1'b0;
      end
   endgenerate

   assign sret_allowed = (priv != PRIV_USER);
   assign mret_allowed = (priv == PRIV_MACH);

   always_comb begin
      op = OP_ILLEGAL;
      if (hit_ecall)                      op = OP_ECALL;
      else if (hit_ebreak)                op = OP_EBREAK;
      else if (hit_uret)                  op = OP_URET;
      else if (hit_sret && sret_allowed)  op = OP_SRET;
      else if (hit_mret && mret_allowed)  op = OP_MRET;
   end

endmodule

// File: rtl/sysret_state.sv
`timescale 1ns/1ps
module sysret_state
   import sysret_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ld,
   input  hart_state_t ld_val,
   input  logic        apply,
   input  sys_op_e     op,
   output hart_state_t st
);

   hart_state_t st_nx;
   hart_state_t popped;

   always_comb begin
      popped = st;
      case (op)
         OP_URET: begin
            popped.uie  = st.upie;
            popped.upie = 1'b1;
         end
         OP_SRET: begin
            popped.priv = {1'b0, st.spp};
            popped.sie  = st.spie;
            popped.spie = 1'b1;
            popped.spp  = 1'b0;
         end
         OP_MRET: begin
            popped.priv = fix_priv(st.mpp);
            popped.mie  = st.mpie;
            popped.mpie = 1'b1;
            popped.mpp  = PRIV_USER;
         end
         default: popped = st;
      endcase
   end

   always_comb begin
      st_nx = st;
      if (ld) begin
         st_nx      = ld_val;
         st_nx.priv = fix_priv(ld_val.priv);
         st_nx.mpp  = fix_priv(ld_val.mpp);
      end else if (apply) begin
         st_nx = popped;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= '0;
         st.priv <= PRIV_MACH;
      end else begin
         st <= st_nx;
      end
   end

endmodule

// File: rtl/sysret_resp.sv
`timescale 1ns/1ps
module sysret_resp
   import sysret_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  sys_op_e            op,
   input  logic [1:0]         priv,
   input  logic [31:0]        instr,
   input  logic [XLEN-1:0]    pc,
   input  logic [XLEN-1:0]    uepc,
   input  logic [XLEN-1:0]    sepc,
   input  logic [XLEN-1:0]    mepc,
   output logic               resp_valid,
   output logic [XLEN-1:0]    next_pc,
   output logic               fault_valid,
   output logic [CAUSE_W-1:0] fault_cause,
   output logic [XLEN-1:0]    fault_value
);

   localparam logic [XLEN-1:0] STEP = XLEN'(4);

   logic [XLEN-1:0]    npc_nx;
   logic               flt_nx;
   logic [CAUSE_W-1:0] cause_nx;
   logic [XLEN-1:0]    val_nx;

   always_comb begin
      npc_nx   = pc + STEP;
      flt_nx   = 1'b0;
      cause_nx = '0;
      val_nx   = '0;
      case (op)
         OP_ECALL: begin
            flt_nx   = 1'b1;
            cause_nx = CAUSE_W'(CAUSE_ECALL_BASE) + CAUSE_W'(priv);
         end
         OP_EBREAK: begin
            flt_nx   = 1'b1;
            cause_nx = CAUSE_W'(CAUSE_BREAK);
            val_nx   = pc;
         end
         OP_URET: npc_nx = uepc;
         OP_SRET: npc_nx = sepc;
         OP_MRET: npc_nx = mepc;
         default: begin
            flt_nx   = 1'b1;
            cause_nx = CAUSE_W'(CAUSE_ILLEGAL);
            val_nx   = XLEN'(instr);
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid  <= 1'b0;
         fault_valid <= 1'b0;
         next_pc     <= '0;
         fault_cause <= '0;
         fault_value <= '0;
      end else begin
         resp_valid  <= fire;
         fault_valid <= fire && flt_nx;
         if (fire) begin
            next_pc     <= npc_nx;
            fault_cause <= cause_nx;
            fault_value <= val_nx;
         end
      end
   end

endmodule

// File: rtl/sysret_unit.sv
`timescale 1ns/1ps
module sysret_unit
   import sysret_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int CAUSE_W   = 4,
   parameter bit HAS_URET  = 1'b1,
   parameter bit HAS_SMODE = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [31:0]        instr_word,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [XLEN-1:0]    uepc,
   input  logic [XLEN-1:0]    sepc,
   input  logic [XLEN-1:0]    mepc,
   input  logic               state_ld,
   input  logic [10:0]        state_ld_val,
   output logic               resp_valid,
   output logic [XLEN-1:0]    next_pc,
   output logic               fault_valid,
   output logic [CAUSE_W-1:0] fault_cause,
   output logic [XLEN-1:0]    fault_value,
   output logic [10:0]        state_q
);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("sysret_unit: XLEN must be at least 32");
      end
      if (CAUSE_W < 4) begin : g_bad_cause
         $error("sysret_unit: CAUSE_W must hold cause 11");
      end
      if (STATE_W != 11) begin : g_bad_state
         $error("sysret_unit: state port width mismatch");
      end
   endgenerate

   hart_state_t st;
   sys_op_e     op;
   logic        fire;

   assign fire = instr_valid && !state_ld;

   sysret_decode #(
      .HAS_URET  (HAS_URET),
      .HAS_SMODE (HAS_SMODE)
   ) u_dec (
      .instr (instr_word),
      .priv  (st.priv),
      .op    (op)
   );

   sysret_state u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (state_ld),
      .ld_val (hart_state_t'(state_ld_val)),
      .apply  (fire),
      .op     (op),
      .st     (st)
   );

   sysret_resp #(
      .XLEN    (XLEN),
      .CAUSE_W (CAUSE_W)
   ) u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (fire),
      .op          (op),
      .priv        (st.priv),
      .instr       (instr_word),
      .pc          (cur_pc),
      .uepc        (uepc),
      .sepc        (sepc),
      .mepc        (mepc),
      .resp_valid  (resp_valid),
      .next_pc     (next_pc),
      .fault_valid (fault_valid),
      .fault_cause (fault_cause),
      .fault_value (fault_value)
   );

   assign state_q = st;

endmodule

// File: rtl/sysret_unit_chk.sv
`timescale 1ns/1ps
module sysret_unit_chk #(
   parameter int XLEN    = 32,
   parameter int CAUSE_W = 4
)(
   input logic               clk,
   input logic               rst_n,
   input logic               instr_valid,
   input logic [31:0]        instr_word,
   input logic [XLEN-1:0]    mepc,
   input logic               state_ld,
   input logic               resp_valid,
   input logic [XLEN-1:0]    next_pc,
   input logic               fault_valid,
   input logic [CAUSE_W-1:0] fault_cause,
   input logic [10:0]        state_q
);

   AST_FAULT_HAS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> resp_valid); // R10

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!instr_valid && !state_ld) |=> ($stable(state_q) && !resp_valid)); // R10

   AST_PRIV_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      state_q[1:0] != 2'b10); // R11

   AST_ECALL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !state_ld && instr_word == 32'h0000_0073)
      |=> (fault_valid && fault_cause == CAUSE_W'(8 + int'($past(state_q[1:0]))))); // R3

   AST_SRET_USER_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !state_ld && instr_word == 32'h1020_0073 && state_q[1:0] == 2'b00)
      |=> (fault_valid && fault_cause == CAUSE_W'(2) && $stable(state_q))); // R7

   AST_MRET_POPS: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !state_ld && instr_word == 32'h3020_0073 && state_q[1:0] == 2'b11)
      |=> (!fault_valid && state_q[5] && state_q[3:2] == 2'b00 && next_pc == $past(mepc))); // R8

   AST_MRET_LOW_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && !state_ld && instr_word == 32'h3020_0073 && state_q[1:0] != 2'b11)
      |=> (fault_valid && $stable(state_q))); // R9

   AST_LOAD_DROPS_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && state_ld) |=> !resp_valid); // R12

endmodule

bind sysret_unit sysret_unit_chk #(
   .XLEN    (XLEN),
   .CAUSE_W (CAUSE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_word  (instr_word),
   .mepc        (mepc),
   .state_ld    (state_ld),
   .resp_valid  (resp_valid),
   .next_pc     (next_pc),
   .fault_valid (fault_valid),
   .fault_cause (fault_cause),
   .state_q     (state_q)
);

// File: tb/sysret_unit_bench.sv
`timescale 1ns/1ps
module sysret_unit_bench;

   localparam int XLEN = 32;
   localparam int CW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            instr_valid = 1'b0;
   logic [31:0]     instr_word = '0;
   logic [XLEN-1:0] cur_pc = 32'h100;
   logic [XLEN-1:0] uepc = 32'h1000;
   logic [XLEN-1:0] sepc = 32'h2000;
   logic [XLEN-1:0] mepc = 32'h3000;
   logic            state_ld = 1'b0;
   logic [10:0]     state_ld_val = '0;
   logic            resp_valid;
   logic [XLEN-1:0] next_pc;
   logic            fault_valid;
   logic [CW-1:0]   fault_cause;
   logic [XLEN-1:0] fault_value;
   logic [10:0]     state_q;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   sysret_unit u_sysret_unit (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .cur_pc(cur_pc), .uepc(uepc), .sepc(sepc), .mepc(mepc),
      .state_ld(state_ld), .state_ld_val(state_ld_val),
      .resp_valid(resp_valid), .next_pc(next_pc), .fault_valid(fault_valid),
      .fault_cause(fault_cause), .fault_value(fault_value), .state_q(state_q)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [10:0] ld;
      logic [31:0] word;
      logic        flt;
      logic [3:0]  cause;
      logic [31:0] val;
      logic [31:0] npc;
      logic [10:0] st;
   } vec_t;

   localparam int NV = 19;
   // state bits: uie sie mie _ upie spie mpie _ spp _ mpp _ priv
   localparam vec_t VEC [NV] = '{
      '{4'd3,  11'b000_000_0_00_11, 32'h0000_0073, 1'b1, 4'd11, 32'h0,         32'h104,  11'b000_000_0_00_11}, // R3 machine
      '{4'd3,  11'b000_000_0_00_00, 32'h0000_0073, 1'b1, 4'd8,  32'h0,         32'h104,  11'b000_000_0_00_00}, // R3 user
      '{4'd3,  11'b000_000_0_00_01, 32'h0000_0073, 1'b1, 4'd9,  32'h0,         32'h104,  11'b000_000_0_00_01}, // R3 supervisor
      '{4'd4,  11'b000_000_0_00_11, 32'h0010_0073, 1'b1, 4'd3,  32'h100,       32'h104,  11'b000_000_0_00_11}, // R4
      '{4'd5,  11'b000_100_0_00_00, 32'h0020_0073, 1'b0, 4'd0,  32'h0,         32'h1000, 11'b100_100_0_00_00}, // R5
      '{4'd5,  11'b100_000_0_00_11, 32'h0020_0073, 1'b0, 4'd0,  32'h0,         32'h1000, 11'b000_100_0_00_11}, // R5
      '{4'd6,  11'b000_010_0_00_01, 32'h1020_0073, 1'b0, 4'd0,  32'h0,         32'h2000, 11'b010_010_0_00_00}, // R6
      '{4'd6,  11'b010_000_1_00_11, 32'h1020_0073, 1'b0, 4'd0,  32'h0,         32'h2000, 11'b000_010_0_00_01}, // R6
      '{4'd7,  11'b000_010_1_00_00, 32'h1020_0073, 1'b1, 4'd2,  32'h1020_0073, 32'h104,  11'b000_010_1_00_00}, // R7
      '{4'd8,  11'b000_001_0_01_11, 32'h3020_0073, 1'b0, 4'd0,  32'h0,         32'h3000, 11'b001_001_0_00_01}, // R8
      '{4'd8,  11'b001_000_0_00_11, 32'h3020_0073, 1'b0, 4'd0,  32'h0,         32'h3000, 11'b000_001_0_00_00}, // R8
      '{4'd8,  11'b000_000_0_11_11, 32'h3020_0073, 1'b0, 4'd0,  32'h0,         32'h3000, 11'b000_001_0_00_11}, // R8
      '{4'd9,  11'b000_001_0_11_01, 32'h3020_0073, 1'b1, 4'd2,  32'h3020_0073, 32'h104,  11'b000_001_0_11_01}, // R9
      '{4'd9,  11'b000_001_0_11_00, 32'h3020_0073, 1'b1, 4'd2,  32'h3020_0073, 32'h104,  11'b000_001_0_11_00}, // R9
      '{4'd2,  11'b000_001_0_01_11, 32'h7b20_0073, 1'b1, 4'd2,  32'h7b20_0073, 32'h104,  11'b000_001_0_01_11}, // R2
      '{4'd2,  11'b000_001_0_01_11, 32'h3020_00f3, 1'b1, 4'd2,  32'h3020_00f3, 32'h104,  11'b000_001_0_01_11}, // R2 rd
      '{4'd2,  11'b000_001_0_01_11, 32'h3020_8073, 1'b1, 4'd2,  32'h3020_8073, 32'h104,  11'b000_001_0_01_11}, // R2 rs1
      '{4'd2,  11'b000_001_0_01_11, 32'h3020_1073, 1'b1, 4'd2,  32'h3020_1073, 32'h104,  11'b000_001_0_01_11}, // R2 funct3
      '{4'd2,  11'b000_001_0_01_11, 32'h3020_0013, 1'b1, 4'd2,  32'h3020_0013, 32'h104,  11'b000_001_0_01_11}  // R2 opcode
   };

   task automatic chk(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_state(input logic [10:0] v);
      @(negedge clk);
      state_ld = 1'b1;
      state_ld_val = v;
      instr_valid = 1'b0;
      @(negedge clk);
      state_ld = 1'b0;
   endtask

   task automatic issue(input logic [31:0] w);
      instr_valid = 1'b1;
      instr_word = w;
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(1, "reset state", 64'(state_q), 64'(11'b000_000_0_00_11));
      chk(1, "reset resp_valid", 64'(resp_valid), 64'd0);
      chk(1, "reset fault_valid", 64'(fault_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         load_state(VEC[i].ld);
         issue(VEC[i].word);
         chk(int'(VEC[i].req), "resp_valid", 64'(resp_valid), 64'd1);
         chk(int'(VEC[i].req), "fault_valid", 64'(fault_valid), 64'(VEC[i].flt));
         chk(int'(VEC[i].req), "next_pc", 64'(next_pc), 64'(VEC[i].npc));
         chk(int'(VEC[i].req), "state", 64'(state_q), 64'(VEC[i].st));
         if (VEC[i].flt) begin
            chk(int'(VEC[i].req), "cause", 64'(fault_cause), 64'(VEC[i].cause));
            chk(int'(VEC[i].req), "value", 64'(fault_value), 64'(VEC[i].val));
         end
      end

      // R10 single-cycle pulse and idle hold
      @(negedge clk);
      chk(10, "resp pulse ends", 64'(resp_valid), 64'd0);
      chk(10, "idle state hold", 64'(state_q), 64'(11'b000_001_0_01_11));

      // R4 breakpoint value follows another PC
      cur_pc = 32'h0000_abc0;
      issue(32'h0010_0073);
      chk(4, "ebreak value", 64'(fault_value), 64'h0000_abc0);
      chk(4, "ebreak next_pc", 64'(next_pc), 64'h0000_abc4);
      cur_pc = 32'h100;

      // R11 reserved privilege codes coerced on load
      load_state(11'b000_000_0_10_10);
      chk(11, "reserved coerced", 64'(state_q), 64'(11'b000_000_0_11_11));

      // R5 back-to-back user returns: uie 0 -> 0 then -> 1
      load_state(11'b000_000_0_00_00);
      instr_valid = 1'b1;
      instr_word = 32'h0020_0073;
      @(negedge clk);
      chk(5, "uret first", 64'(state_q), 64'(11'b000_100_0_00_00));
      @(negedge clk);
      instr_valid = 1'b0;
      chk(5, "uret second", 64'(state_q), 64'(11'b100_100_0_00_00));
      chk(10, "back-to-back resp", 64'(resp_valid), 64'd1);

      // R12 load collides with an instruction
      @(negedge clk);
      state_ld = 1'b1;
      state_ld_val = 11'b000_001_0_01_11;
      instr_valid = 1'b1;
      instr_word = 32'h3020_0073;
      @(negedge clk);
      state_ld = 1'b0;
      instr_valid = 1'b0;
      chk(12, "collision no resp", 64'(resp_valid), 64'd0);
      chk(12, "collision state", 64'(state_q), 64'(11'b000_001_0_01_11));

      // R1 reset again restores machine mode
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(1, "re-reset state", 64'(state_q), 64'(11'b000_000_0_00_11));

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule